// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Style Detector

This block watches sixteen general-purpose input pins and keeps one sticky interrupt status bit for each of them. Software picks a detection style for every pin: a level style (input high or input low), an edge style (rising or falling), or a transitional style that fires on either edge. The chosen condition is looked for on a synchronised copy of the pin. When it is found, the pin's status bit is latched and its interrupt request output goes high. The bit stays set until software writes a one to it in the status register.

The style fields are packed three bits per pin across two configuration words, eight pins per word, so that software can change one pin's style with a read-modify-write of a single field. For level styles, a clear is overridden for as long as the condition holds, so the request cannot be dismissed until the input goes back to its idle level. Edge latches stay set after the input settles until they are cleared.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, every style field reads 0, every status bit reads 0 and every irq output is low.
- R2: Word address 0 holds the styles of pins 0..7 and word address 1 those of pins 8..15. Pin n's 3-bit field sits at bits [3*(n%8)+2 : 3*(n%8)], bits 31..24 read as zero, and both words read back what was written.
- R3: Style 0 (active high) sets a pin's status bit while its synchronised input is high. An input change seen at clock edge k shows on irq at edge k+2 and not before.
- R4: Style 1 (active low) sets a pin's status bit while its synchronised input is low. After the input returns high, the bit can be cleared.
- R5: Style 2 (rising) sets the status bit on a 0-to-1 change of the synchronised input and not on a 1-to-0 change.
- R6: Style 3 (falling) sets the status bit on a 1-to-0 change and not on a 0-to-1 change.
- R7: Style 4 (transitional) sets the status bit on either change.
- R8: Style codes 5, 6 and 7 never set the status bit.
- R9: Word address 2 reads the status bits in bits 15..0, with bits 31..16 as zero. Writing a 1 to bit n clears pin n's status unless its condition is present in that cycle. Writing a 0 leaves the bit as it is.
- R10: While a pin's condition holds, a clear is overridden and the status bit stays set.
- R11: A status bit set by an edge stays set after the input returns to idle, for as long as no clear is written.
- R12: irq_o[n] always equals status bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 4 | Word address: 0 and 1 style words, 2 status |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed word, combinational |
| pins_i | input | 16 | Asynchronous pin inputs |
| irq_o | output | 16 | Per-pin interrupt request, equal to status |

## Verification
One directed pass gives every pin a different style and moves all pins together. A single rising step therefore separates rising, transitional, falling and disabled pins, and the matching falling step separates them the other way. Clears are written while some level conditions still hold and others have ended. This shows that a held condition wins over a clear and that a zero in the clear mask leaves an edge latch untouched. A single-pin step, checked cycle by cycle, pins down the two-edge latency. A long random phase with random style writes and clears follows, compared against a behavioural model on every clock.

// File: rtl/gpio_irq_pkg.sv
// Package: shared style codes and field geometry for the GPIO interrupt detector.
// Assumes every style field is STYLE_W bits wide; codes above STY_BOTH disable detection.
package gpio_irq_pkg;
    localparam int STYLE_W = 3;

    typedef enum logic [STYLE_W-1:0] {
        STY_HIGH = 3'd0,
        STY_LOW  = 3'd1,
        STY_RISE = 3'd2,
        STY_FALL = 3'd3,
        STY_BOTH = 3'd4
    } style_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Module: two-flop synchroniser per pin plus a one-cycle delayed copy for edge finding.
// Assumes pins are asynchronous to clk; outputs are registered and reset to zero.
module gpio_in_sync #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] sync_o,
    output logic [NUM_PINS-1:0] prev_o
);
    logic [NUM_PINS-1:0] meta_q;

    // Shift each pin through two flops, then keep the previous synchronised value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= pins_i;
            sync_o <= meta_q;
            prev_o <= sync_o;
        end
    end

    // R3
    prev_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (prev_o == $past(sync_o)));
endmodule

// File: rtl/gpio_style_regs.sv
// Module: per-pin style storage, written one word at a time, PINS_PER_REG fields per word.
// Assumes word address r (0..NUM_REGS-1) selects pins r*PINS_PER_REG and up.
module gpio_style_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS     = 16,
    parameter int PINS_PER_REG = 8,
    parameter int ADDR_W       = 4,
    localparam int NUM_REGS    = NUM_PINS / PINS_PER_REG,
    localparam int FIELD_BITS  = PINS_PER_REG * STYLE_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_i,
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [FIELD_BITS-1:0]              wdata_i,
    output logic [NUM_PINS-1:0][STYLE_W-1:0]   style_o
);
    // Load the fields of the addressed word; reset gives style 0 everywhere.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style_o <= '0;
        end else if (wr_i) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (addr_i == ADDR_W'(r)) begin
                    for (int k = 0; k < PINS_PER_REG; k++) begin
                        style_o[r*PINS_PER_REG + k] <= wdata_i[k*STYLE_W +: STYLE_W];
                    end
                end
            end
        end
    end

    // R2
    style_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(style_o));
endmodule

// File: rtl/gpio_cond_detect.sv
// Module: decodes each pin's style and flags the condition on the synchronised input.
// Assumes sync_i/prev_i are the current and one-cycle-old synchronised pin values.
module gpio_cond_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0][STYLE_W-1:0] style_i,
    input  logic [NUM_PINS-1:0]              sync_i,
    input  logic [NUM_PINS-1:0]              prev_i,
    output logic [NUM_PINS-1:0]              cond_o
);
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        // Select the condition for this pin from its style code.
        always_comb begin
            case (style_i[n])
                STY_HIGH: cond_o[n] = sync_i[n];
                STY_LOW:  cond_o[n] = !sync_i[n];
                STY_RISE: cond_o[n] = sync_i[n] && !prev_i[n];
                STY_FALL: cond_o[n] = !sync_i[n] && prev_i[n];
                STY_BOTH: cond_o[n] = sync_i[n] != prev_i[n];
                default:  cond_o[n] = 1'b0;
            endcase
        end

        // R8
        disabled_style_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (style_i[n] > STY_BOTH) |-> !cond_o[n]);

        // R5
        rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (style_i[n] == STY_RISE && cond_o[n]) |-> (sync_i[n] && !prev_i[n]));
    end
endmodule

// File: rtl/gpio_status.sv
// Module: sticky per-pin status; a present condition sets, a write-one mask clears.
// Assumes set wins over clear in the same cycle, so held level conditions survive a clear.
module gpio_status #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] cond_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NUM_PINS-1:0] status_o
);
    // Keep uncleared bits, then OR in any condition present this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= (status_o & ~clr_i) | cond_i;
    end

    // R10
    cond_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(cond_i)) == $past(cond_i)));

    // R9
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(clr_i & ~cond_i)) == '0));

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));

    // R1
    set_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(cond_i)) == '0));
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: top of the GPIO interrupt style detector; register bus, read mux and wiring.
// Assumes word addresses 0..NUM_REGS-1 are style words and NUM_REGS is the status word.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS     = 16,
    parameter int PINS_PER_REG = 8,
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    localparam int NUM_REGS    = NUM_PINS / PINS_PER_REG,
    localparam int FIELD_BITS  = PINS_PER_REG * STYLE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_wr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] irq_o
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_REGS);

    logic [NUM_PINS-1:0][STYLE_W-1:0] style;
    logic [NUM_PINS-1:0]              sync_v, prev_v, cond_v, status_v, clr_v;
    logic                             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:FIELD_BITS];

    // Form the write-one clear mask for the status word.
    assign clr_v = (bus_wr_i && bus_addr_i == STAT_ADDR) ? bus_wdata_i[NUM_PINS-1:0] : '0;

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .sync_o(sync_v), .prev_o(prev_v)
    );

    gpio_style_regs #(.NUM_PINS(NUM_PINS), .PINS_PER_REG(PINS_PER_REG), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i[FIELD_BITS-1:0]), .style_o(style)
    );

    gpio_cond_detect #(.NUM_PINS(NUM_PINS)) det_i (
        .clk(clk), .rst_n(rst_n), .style_i(style), .sync_i(sync_v), .prev_i(prev_v), .cond_o(cond_v)
    );

    gpio_status #(.NUM_PINS(NUM_PINS)) stat_i (
        .clk(clk), .rst_n(rst_n), .cond_i(cond_v), .clr_i(clr_v), .status_o(status_v)
    );

    assign irq_o = status_v;

    // Return the addressed word: packed style fields or zero-extended status.
    always_comb begin
        bus_rdata_o = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (bus_addr_i == ADDR_W'(r)) begin
                for (int k = 0; k < PINS_PER_REG; k++) begin
                    bus_rdata_o[k*STYLE_W +: STYLE_W] = style[r*PINS_PER_REG + k];
                end
            end
        end
        if (bus_addr_i == STAT_ADDR) bus_rdata_o[NUM_PINS-1:0] = status_v;
    end

    // R12
    irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr_i == STAT_ADDR) |-> (bus_rdata_o[NUM_PINS-1:0] == irq_o));
endmodule

// File: tb/gpio_irq_detect_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model stepped every clock plus directed style scenarios.
module gpio_irq_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic        wr = 1'b0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic [15:0] pins = 16'd0;
    logic [15:0] irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state
    bit [15:0] m_s1, m_s2, m_prev, m_stat;
    int        m_style[16];

    always #10 clk = ~clk;

    gpio_irq_detect dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pins_i(pins), .irq_o(irq)
    );

    function automatic bit mcond(int sty, bit s, bit p);
        case (sty)
            0: return s;
            1: return !s;
            2: return s && !p;
            3: return !s && p;
            4: return s != p;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit [31:0] mread(logic [3:0] a);
        bit [31:0] v = 32'd0;
        if (a == 4'd0 || a == 4'd1)
            for (int k = 0; k < 8; k++) v[k*3 +: 3] = 3'(m_style[a*8 + k]);
        else if (a == 4'd2) v[15:0] = m_stat;
        return v;
    endfunction

    // Model step at every rising edge using the inputs held since the last falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_stat = '0;
            for (int i = 0; i < 16; i++) m_style[i] = 0;
        end else begin
            bit [15:0] cnd, clr;
            for (int i = 0; i < 16; i++) cnd[i] = mcond(m_style[i], m_s2[i], m_prev[i]);
            clr = (wr && addr == 4'd2) ? wdata[15:0] : 16'd0;
            m_stat = (m_stat & ~clr) | cnd;
            if (wr && (addr == 4'd0 || addr == 4'd1))
                for (int k = 0; k < 8; k++) m_style[addr*8 + k] = int'(wdata[k*3 +: 3]);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
        end
    end

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R12 irq, R9/R2 read data).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq == m_stat, "R12 model irq", {16'd0, irq}, {16'd0, m_stat});
            check(rdata == mread(addr), "R9 model rdata", rdata, mread(addr));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step(1);
        wr = 1'b0;
    endtask

    task automatic read_check(logic [3:0] a, logic [31:0] exp, string req);
        addr = a; #1;
        check(rdata == exp, req, rdata, exp);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check(irq == 16'd0, "R1 irq after reset", {16'd0, irq}, 32'd0);
        read_check(4'd0, 32'd0, "R1 style word 0");
        read_check(4'd1, 32'd0, "R1 style word 1");
        read_check(4'd2, 32'd0, "R1 status");

        // R3 latency: pin0 style high, change sampled at edge k, irq at k+2
        pins[0] = 1'b1;
        step(1);
        step(1);
        check(irq[0] == 1'b0, "R3 not before k+2", {31'd0, irq[0]}, 32'd0);
        step(1);
        check(irq[0] == 1'b1, "R3 set at k+2", {31'd0, irq[0]}, 32'd1);
        pins[0] = 1'b0;
        step(3);
        bus_write(4'd2, 32'h0000_FFFF);
        step(1);
        check(irq == 16'd0, "R3 clears once low", {16'd0, irq}, 32'd0);

        // R2 field layout: one style per pin
        bus_write(4'd0, 32'hFF1E_C688);
        bus_write(4'd1, 32'h0000_0010);
        read_check(4'd0, 32'h001E_C688, "R2 word 0 readback");
        read_check(4'd1, 32'h0000_0010, "R2 word 1 readback");
        step(3);
        bus_write(4'd2, 32'h0000_FFFF);
        step(2);
        check(irq == 16'h0002, "R10 active-low held over clear", {16'd0, irq}, 32'h2);

        // Rising step on pins 0,2,3,4,5,6,9
        pins = 16'h027D;
        step(4);
        check(irq == 16'h0217, "R5 R6 R7 R8 R2 rising step", {16'd0, irq}, 32'h217);
        check(irq[3] == 1'b0, "R6 falling style ignores rise", {31'd0, irq[3]}, 32'd0);
        check(irq[6:5] == 2'b00, "R8 disabled codes", {30'd0, irq[6:5]}, 32'd0);
        bus_write(4'd2, 32'h0000_FFFF);
        step(2);
        check(irq == 16'h0003, "R10 R9 clear with levels held", {16'd0, irq}, 32'h3);
        read_check(4'd2, 32'h0000_0003, "R9 status word");

        // Falling step
        pins = 16'h0000;
        step(4);
        check(irq == 16'h001B, "R6 R7 R5 falling step", {16'd0, irq}, 32'h1B);
        bus_write(4'd2, 32'h0000_0008);
        step(1);
        check(irq == 16'h0013, "R9 single-bit clear", {16'd0, irq}, 32'h13);
        step(10);
        check(irq[4] == 1'b1, "R11 edge latch sticky", {31'd0, irq[4]}, 32'd1);

        // R4 active low releases once high
        pins[1] = 1'b1;
        step(4);
        bus_write(4'd2, 32'h0000_0002);
        step(1);
        check(irq == 16'h0011, "R4 clear after pin high", {16'd0, irq}, 32'h11);
        bus_write(4'd2, 32'h0000_0011);
        step(1);
        check(irq == 16'h0000, "R9 all clear", {16'd0, irq}, 32'd0);

        // Random phase
        for (int c = 0; c < 3000; c++) begin
            pins = 16'($urandom);
            if ($urandom_range(0, 7) == 0) begin
                addr = 4'($urandom_range(0, 3));
                wdata = $urandom;
                wr = 1'b1;
            end else begin
                wr = 1'b0;
                addr = 4'($urandom_range(0, 3));
            end
            step(1);
        end
        wr = 1'b0;
        step(1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule